// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block sets the bit timing of an I2C master. From the system clock and one 32-bit divider word it produces the SCL level and four single-cycle strobes. The bit engine uses these strobes to place SDA edges and to sample SDA. The divider word has two 16-bit fields. The lower field sets the length of the SCL low phase and the upper field sets the length of the high phase. Each field counts in units of eight system clocks, so the SCL frequency is the system clock divided by 8 × (low field + high field). For a symmetric clock, software writes half of the total divisor, rounded up, into each field. Typical targets are 100 kHz, or up to 400 kHz.

The bit engine changes SDA on the data strobe in the middle of the low phase. It samples SDA on the sample strobe in the middle of the high phase. The same high-phase midpoint is where a START or STOP edge on SDA is placed, so the time before and after that point gives the setup and hold margins around it. The fall and rise strobes mark the first cycle of each phase. A new divider word is captured only when a low phase begins, so a period is never stretched or cut in the middle. When the block is disabled, SCL is released high and all timing state returns to its idle value.

Top module: `sclgen_timing`

## Requirements
- R1: While the enable input is low (and from reset), `scl_o` is 1 and all four strobes are 0; changes on `div_i` during that time have no effect on any output.
- R2: A clock edge that samples the enable high while the block is idle starts a low phase in the following cycle: `scl_o` is 0 and `fall_stb_o` is 1 in that cycle.
- R3: The low phase lasts exactly 8 × N_lo system clocks, where N_lo is `div_i[15:0]`.
- R4: The high phase lasts exactly 8 × N_hi system clocks, where N_hi is `div_i[31:16]`. A high phase follows each low phase, and a low phase follows each high phase, with no gap while enabled.
- R5: A field value of 0 acts as 1, giving an 8-clock phase.
- R6: `data_stb_o` is high for one cycle per low phase, at clock index 4 × N_lo counted from the first low cycle (index 0).
- R7: `samp_stb_o` is high for one cycle per high phase, at clock index 4 × N_hi counted from the first high cycle (index 0).
- R8: `div_i` is captured only on the edge that starts a low phase. That captured value sets the lengths of that low phase and the following high phase; a change at any other time first applies to the next period.
- R9: When the enable is sampled low in the middle of a phase, the next cycle has `scl_o` = 1 and no strobes. A later enable restarts from the beginning of a low phase.
- R10: `fall_stb_o` is high only in the first low cycle and `rise_stb_o` only in the first high cycle. At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| en_i | input | 1 | Run the SCL timing when high |
| div_i | input | 32 | [15:0] low-phase field, [31:16] high-phase field, in 8-clock units |
| scl_o | output | 1 | SCL level: 0 drives low, 1 releases |
| fall_stb_o | output | 1 | First cycle of the low phase |
| data_stb_o | output | 1 | Low-phase midpoint, SDA may change |
| rise_stb_o | output | 1 | First cycle of the high phase |
| samp_stb_o | output | 1 | High-phase midpoint, SDA sample point |

## Verification
The bench uses the smallest fields, including zero, where an off-by-one in the unit scaling or a missing clamp would give a zero-length or 16-clock phase. It also runs asymmetric and larger fields, where swapping the two halves or halving the midpoint wrong moves the data or sample strobe. Divider updates are made in the middle of a low phase and in the very last high cycle. A design that loads the fields early, or reloads them at the high phase, would stretch or cut the current period. Disabling inside a phase checks that SCL is released at once and that the restart begins with a full low phase, not a leftover count.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  typedef struct packed {
    logic fall;
    logic data;
    logic rise;
    logic samp;
  } scl_strobes_t;

endpackage

// File: rtl/sclgen_field_latch.sv
module sclgen_field_latch #(
  parameter int FIELD_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [2*FIELD_W-1:0]   div_i,
  output logic [FIELD_W-1:0]     lo_n_o,
  output logic [FIELD_W-1:0]     hi_n_o
);

  localparam int NUM_FIELDS = 2;

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_q;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [FIELD_W-1:0] raw;
    logic [FIELD_W-1:0] fld_d;

    always_comb begin
      raw   = div_i[g*FIELD_W +: FIELD_W];
      fld_d = (raw == '0) ? FIELD_W'(1) : raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q[g] <= FIELD_W'(1);
      end else if (load_i) begin
        fld_q[g] <= fld_d;
      end
    end
  end

  assign lo_n_o = fld_q[0];
  assign hi_n_o = fld_q[1];

endmodule

// File: rtl/sclgen_phase_ctr.sv
module sclgen_phase_ctr
  import sclgen_pkg::*;
#(
  parameter int FIELD_W   = 16,
  parameter int UNIT_LOG2 = 3,
  localparam int CNT_W    = FIELD_W + UNIT_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] lo_n_i,
  input  logic [FIELD_W-1:0] hi_n_i,
  output logic               active_o,
  output scl_phase_e         phase_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               load_o
);

  logic             active_q, active_d;
  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cur_len;
  logic             phase_end;
  logic             state_ce;

  always_comb begin
    cur_len   = (phase_q == PH_HIGH) ? (CNT_W'(hi_n_i) << UNIT_LOG2)
                                     : (CNT_W'(lo_n_i) << UNIT_LOG2);
    phase_end = (cnt_q == cur_len - CNT_W'(1));
    load_o    = en_i && (!active_q || (phase_q == PH_HIGH && phase_end));
    state_ce  = en_i || active_q;
  end

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    if (!en_i) begin
      active_d = 1'b0;
      phase_d  = PH_LOW;
      cnt_d    = '0;
    end else if (!active_q) begin
      active_d = 1'b1;
      phase_d  = PH_LOW;
      cnt_d    = '0;
    end else if (phase_end) begin
      phase_d  = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      cnt_d    = '0;
    end else begin
      cnt_d    = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_LOW;
      cnt_q    <= '0;
    end else if (state_ce) begin
      active_q <= active_d;
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/sclgen_timing.sv
module sclgen_timing
  import sclgen_pkg::*;
#(
  parameter int FIELD_W   = 16,
  parameter int UNIT_LOG2 = 3,
  localparam int DIV_W    = 2 * FIELD_W,
  localparam int CNT_W    = FIELD_W + UNIT_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             scl_o,
  output logic             fall_stb_o,
  output logic             data_stb_o,
  output logic             rise_stb_o,
  output logic             samp_stb_o
);

  logic [FIELD_W-1:0] lo_n, hi_n;
  logic               active;
  scl_phase_e         phase;
  logic [CNT_W-1:0]   cnt;
  logic               load;
  logic [CNT_W-1:0]   lo_mid, hi_mid;
  scl_strobes_t       stb;

  sclgen_field_latch #(
    .FIELD_W (FIELD_W)
  ) u_fields (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .div_i  (div_i),
    .lo_n_o (lo_n),
    .hi_n_o (hi_n)
  );

  sclgen_phase_ctr #(
    .FIELD_W   (FIELD_W),
    .UNIT_LOG2 (UNIT_LOG2)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .lo_n_i   (lo_n),
    .hi_n_i   (hi_n),
    .active_o (active),
    .phase_o  (phase),
    .cnt_o    (cnt),
    .load_o   (load)
  );

  always_comb begin
    lo_mid   = CNT_W'(lo_n) << (UNIT_LOG2 - 1);
    hi_mid   = CNT_W'(hi_n) << (UNIT_LOG2 - 1);
    stb.fall = active && (phase == PH_LOW)  && (cnt == '0);
    stb.data = active && (phase == PH_LOW)  && (cnt == lo_mid);
    stb.rise = active && (phase == PH_HIGH) && (cnt == '0);
    stb.samp = active && (phase == PH_HIGH) && (cnt == hi_mid);
  end

  assign scl_o      = !active || (phase == PH_HIGH);
  assign fall_stb_o = stb.fall;
  assign data_stb_o = stb.data;
  assign rise_stb_o = stb.rise;
  assign samp_stb_o = stb.samp;

endmodule

// File: rtl/sclgen_timing_checker.sv
module sclgen_timing_checker #(
  parameter int UNIT_LOG2 = 3,
  parameter int CW        = 24
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic scl_o,
  input logic fall_stb_o,
  input logic data_stb_o,
  input logic rise_stb_o,
  input logic samp_stb_o
);

  logic [CW-1:0] lo_cnt;
  logic          seen_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt    <= '0;
      seen_fall <= 1'b0;
    end else begin
      if (fall_stb_o) begin
        lo_cnt    <= CW'(1);
        seen_fall <= 1'b1;
      end else if (!scl_o) begin
        lo_cnt    <= lo_cnt + CW'(1);
      end
      if (!en_i) seen_fall <= 1'b0;
    end
  end

  assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (scl_o && !fall_stb_o && !data_stb_o && !rise_stb_o && !samp_stb_o));

  assert_enable_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i ##1 en_i) |=> (fall_stb_o && !scl_o));

  assert_low_len_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb_o && seen_fall) |-> (lo_cnt[UNIT_LOG2-1:0] == '0 && lo_cnt != '0));

  assert_data_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb_o |-> !scl_o);

  assert_samp_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb_o |-> scl_o);

  assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb_o, data_stb_o, rise_stb_o, samp_stb_o}));

  assert_fall_marks_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> fall_stb_o);

  assert_rise_marks_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_o) && $past(en_i)) |-> rise_stb_o);

endmodule

bind sclgen_timing sclgen_timing_checker #(
  .UNIT_LOG2 (UNIT_LOG2)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .scl_o      (scl_o),
  .fall_stb_o (fall_stb_o),
  .data_stb_o (data_stb_o),
  .rise_stb_o (rise_stb_o),
  .samp_stb_o (samp_stb_o)
);

// File: tb/sclgen_timing_bench.sv
`timescale 1ns/1ps
module sclgen_timing_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] div;
  logic        scl, fall, data, rise, samp;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sclgen_timing u_sclgen_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .div_i      (div),
    .scl_o      (scl),
    .fall_stb_o (fall),
    .data_stb_o (data),
    .rise_stb_o (rise),
    .samp_stb_o (samp)
  );

  function automatic int eff(input logic [15:0] f);
    return (f == 16'd0) ? 1 : int'(f);
  endfunction

  function automatic logic [4:0] obs();
    return {scl, fall, data, rise, samp};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One full SCL period with cur in force; optionally place nxt on div
  // (upd_at 1: low index 2, upd_at 2: last high cycle).
  task automatic run_period(input logic [31:0] cur, input logic [31:0] nxt,
                            input int upd_at, input string req);
    int nlo = eff(cur[15:0]);
    int nhi = eff(cur[31:16]);
    bit bad_lo = 0, bad_hi = 0;
    logic [4:0] a_lo = '0, e_lo = '0, a_hi = '0, e_hi = '0;
    for (int i = 0; i < 8*nlo; i++) begin
      logic [4:0] e;
      @(negedge clk);
      e = {1'b0, (i == 0), (i == 4*nlo), 1'b0, 1'b0};
      if (obs() !== e && !bad_lo) begin bad_lo = 1; a_lo = obs(); e_lo = e; end
      if (upd_at == 1 && i == 2) div = nxt;
    end
    chk(!bad_lo, {req, " low phase R3 R6 R10"}, int'(a_lo), int'(e_lo));
    for (int i = 0; i < 8*nhi; i++) begin
      logic [4:0] e;
      @(negedge clk);
      e = {1'b1, 1'b0, 1'b0, (i == 0), (i == 4*nhi)};
      if (obs() !== e && !bad_hi) begin bad_hi = 1; a_hi = obs(); e_hi = e; end
      if (upd_at == 2 && i == 8*nhi - 1) div = nxt;
    end
    chk(!bad_hi, {req, " high phase R4 R7 R10"}, int'(a_hi), int'(e_hi));
  endtask

  task automatic check_idle(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(obs() == 5'b10000, req, int'(obs()), 5'b10000);
      div = div ^ 32'h0005_0003;
    end
  endtask

  initial begin
    logic [31:0] cur, nxt;
    void'($urandom(32'd4711));
    rst_n = 1'b0; en = 1'b0; div = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and idle, divider toggling ignored
    check_idle(3, "R1 idle after reset");

    // R2 R3 R4: start and two back-to-back periods
    @(negedge clk); div = {16'd3, 16'd2}; en = 1'b1;
    run_period({16'd3, 16'd2}, 32'h0, 0, "R2 first period");
    run_period({16'd3, 16'd2}, 32'h0, 0, "R4 continuous period");

    // R8: update mid low, then in last high cycle
    run_period({16'd3, 16'd2}, {16'd1, 16'd4}, 1, "R8 update mid-low");
    run_period({16'd1, 16'd4}, {16'd5, 16'd1}, 2, "R8 new value, update at end");
    run_period({16'd5, 16'd1}, {16'd0, 16'd0}, 1, "R8 late update");
    // R5: both fields zero act as one
    run_period({16'd0, 16'd0}, {16'd0, 16'd6}, 1, "R5 zero fields");
    run_period({16'd0, 16'd6}, {16'd7, 16'd0}, 1, "R5 zero high field");
    run_period({16'd7, 16'd0}, {16'h0100, 16'd300}, 1, "R5 zero low field");
    run_period({16'h0100, 16'd300}, {16'd2, 16'd2}, 1, "R3 R4 large fields");
    run_period({16'd2, 16'd2}, {16'd2, 16'd2}, 0, "R3 equal halves");

    // R9: disable inside a low phase
    repeat (5) @(negedge clk);
    en = 1'b0;
    check_idle(1, "R9 release after disable in low");
    check_idle(4, "R1 idle ignores divider");
    div = {16'd1, 16'd3}; en = 1'b1;
    run_period({16'd1, 16'd3}, 32'h0, 0, "R9 restart from low");
    // R9: disable inside a high phase
    repeat (8*3 + 3) @(negedge clk);
    en = 1'b0;
    check_idle(1, "R9 release after disable in high");
    div = {16'd2, 16'd1}; en = 1'b1;
    run_period({16'd2, 16'd1}, 32'h0, 0, "R9 restart after high");

    // Random periods, next divider placed mid-low or at last high cycle
    cur = {16'd2, 16'd1};
    for (int k = 0; k < 24; k++) begin
      nxt = {16'($urandom % 20), 16'($urandom % 20)};
      run_period(cur, nxt, 1 + (k % 2), "R8 random");
      cur = nxt;
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule